// File: doc/BRIEF.md
# Asynchronous External Memory Write Sequencer

This block is a bus master that runs write cycles to external asynchronous memory such as SRAM or flash. It runs on the memory-interface clock. An internal client hands it one write at a time over a valid/ready port. Each write carries an address, a data word and a bank number. The block turns each accepted write into a timed pin sequence on the external bus:

1. Address and an active-low bank select come first.
2. One clock later an active-low write strobe goes low and the data driver is enabled.
3. The strobe stays low for a programmed number of wait clocks. An external acknowledge can stretch it further.
4. Address, select and data are then held for a programmed number of hold clocks.
5. A turnaround clock follows before the port takes the next request.

The read strobe is part of the bus but is never pulsed by this block. The data bus is presented as a value plus a driver enable, and a pad cell at the chip edge builds the tri-state buffer from them.

Timing comes from three configuration inputs, all captured when a request is accepted:
- a wait count, where zero counts as one clock;
- a hold count;
- an acknowledge-enable bit.

The acknowledge pin is asynchronous, so it passes through a two-stage synchronizer before the controller looks at it.

The controller is a six-state machine:
- IDLE: ready is high. On a valid request it goes to SETUP.
- SETUP: address and select are driven and the strobe is still high. It always goes to STROBE.
- STROBE: the strobe is low and data is driven. It stays for the effective wait count. At the end it goes to ACKWAIT if acknowledge is enabled and the synchronized acknowledge is low. Otherwise it goes to HOLD if the hold count is nonzero, or to GAP if it is zero.
- ACKWAIT: the strobe stays low until the synchronized acknowledge is high. It then goes to HOLD or GAP by the same hold rule.
- HOLD: the strobe is high while address, select and data stay driven. It lasts for the hold count and then goes to GAP.
- GAP: select is released and the data driver is off. It lasts one clock and then returns to IDLE.

Top module: `amw_write_seq`

## Requirements
- R1: In IDLE, and in the clock after a synchronous reset (even one applied in the middle of a write), every bank select, the write strobe and the read strobe are high, the data enable is low and ready is high.
- R2: Ready is high only in IDLE. A request is taken at a rising edge where valid and ready are both high. Ready stays low from then until the write has finished its GAP clock.
- R3: In the first clock after acceptance, the address output equals the request address. Exactly one select is low: bit `req_bank` of the active-low select vector. The write strobe is still high, so select leads the strobe by one full clock.
- R4: The write strobe is low for exactly max(W,1) clocks when no acknowledge stretching applies, where W is the 5-bit wait count.
- R5: The data enable is high and the data output equals the request data for every clock in which the write strobe is low, and for every hold clock.
- R6: After the strobe rises, select, address and data enable stay asserted for exactly H clocks, where H is the 3-bit hold count. They are then released for one GAP clock before ready returns.
- R7: With a second request waiting, its strobe falls exactly H+3 clocks after the previous strobe rose. This is at least 1+H.
- R8: The data enable drops at least two clocks before the next strobe falls.
- R9: With acknowledge enabled, if the synchronized acknowledge is low when the wait count expires, the strobe stays low. After the acknowledge pin rises, the strobe stays low for two more clocks and is high in the third.
- R10: With acknowledge enabled low, a low acknowledge pin has no effect and the strobe width is max(W,1).
- R11: Changing the configuration inputs or request fields after acceptance does not change the running write.
- R12: The read strobe stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wait | input | 5 | Wait count W (0 acts as 1) |
| cfg_hold | input | 3 | Hold count H |
| cfg_ack_en | input | 1 | Allow acknowledge stretching |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 24 | Write address |
| req_data | input | 32 | Write data |
| req_bank | input | 2 | Bank number to select |
| mem_ack | input | 1 | Asynchronous acknowledge from memory |
| mem_addr | output | 24 | External address |
| mem_sel_n | output | 4 | Active-low bank selects |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe (held high) |
| mem_dq_o | output | 32 | Data for the bus pad |
| mem_dq_oe | output | 1 | Data pad driver enable |

## Verification
Single writes are tried with wait counts of 0, 1, 4 and 31, hold counts of 0, 3 and 7, and every bank. This separates the zero-as-one wait rule, the skip of HOLD, the full hold range and the select decode. A back-to-back pair with valid held high measures the strobe-to-strobe spacing and the data-release lead against an exact count. Writes with a low acknowledge are run twice. With acknowledge enabled, the three-clock release latency is measured. With it disabled, the width must equal the plain width. Scrambling configuration after acceptance, and a reset in the middle of a strobe, show that captured values and the reset path govern the pins.

// File: rtl/amw_pkg.sv
package amw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_ACKWAIT = 3'd3,
        ST_HOLD    = 3'd4,
        ST_GAP     = 3'd5
    } amw_state_e;

    function automatic int unsigned amw_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/amw_sync.sv
module amw_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/amw_timer.sv
module amw_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/amw_bank_dec.sv
module amw_bank_dec #(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = 2
) (
    input  logic              active,
    input  logic [BANK_W-1:0] bank,
    output logic [NBANK-1:0]  sel_n
);
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        assign sel_n[i] = ~(active && (bank == BANK_W'(i)));
    end
endmodule

// File: rtl/amw_write_seq.sv
module amw_write_seq
    import amw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 24,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NBANK       = 4,
    parameter int unsigned WAIT_W      = 5,
    parameter int unsigned HOLD_W      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned BANK_W     = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned CNT_W      = amw_max(WAIT_W, HOLD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              cfg_ack_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBANK-1:0]  mem_sel_n,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe
);

    amw_state_e state, state_nx;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [BANK_W-1:0] bank_q;
    logic [WAIT_W-1:0] wait_q;
    logic [HOLD_W-1:0] hold_q;
    logic              ack_en_q;
    logic              accept;
    logic              ack_s;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              bus_active;
    logic              strobe_low;
    logic              drive_data;

    amw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (mem_ack),
        .q   (ack_s)
    );

    amw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    amw_bank_dec #(.NBANK(NBANK), .BANK_W(BANK_W)) u_bank_dec (
        .active (bus_active),
        .bank   (bank_q),
        .sel_n  (mem_sel_n)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Capture the request and its timing configuration at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            data_q   <= '0;
            bank_q   <= '0;
            wait_q   <= WAIT_W'(1);
            hold_q   <= '0;
            ack_en_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= req_addr;
            data_q   <= req_data;
            bank_q   <= req_bank;
            wait_q   <= (cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;
            hold_q   <= cfg_hold;
            ack_en_q <= cfg_ack_en;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and timer loads
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = ST_SETUP;
                end
            end
            ST_SETUP: begin
                state_nx = ST_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(wait_q - 1'b1);
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    if (ack_en_q && !ack_s) begin
                        state_nx = ST_ACKWAIT;
                    end else if (hold_q != '0) begin
                        state_nx = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(hold_q - 1'b1);
                    end else begin
                        state_nx = ST_GAP;
                    end
                end
            end
            ST_ACKWAIT: begin
                if (ack_s) begin
                    if (hold_q != '0) begin
                        state_nx = ST_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(hold_q - 1'b1);
                    end else begin
                        state_nx = ST_GAP;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    state_nx = ST_GAP;
                end
            end
            ST_GAP: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Output decode from the state register
    always_comb begin
        bus_active = 1'b0;
        strobe_low = 1'b0;
        drive_data = 1'b0;
        unique case (state)
            ST_IDLE, ST_GAP: begin
                bus_active = 1'b0;
            end
            ST_SETUP: begin
                bus_active = 1'b1;
            end
            ST_STROBE, ST_ACKWAIT: begin
                bus_active = 1'b1;
                strobe_low = 1'b1;
                drive_data = 1'b1;
            end
            ST_HOLD: begin
                bus_active = 1'b1;
                drive_data = 1'b1;
            end
            default: begin
                bus_active = 1'b0;
            end
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wr_n  = ~strobe_low;
    assign mem_rd_n  = 1'b1;
    assign mem_dq_o  = data_q;
    assign mem_dq_oe = drive_data;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((&mem_sel_n) && mem_wr_n && !mem_dq_oe));

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_sel_n));

    // R3
    strobe_after_sel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_wr_n) |-> !$past(&mem_sel_n));

    // R5
    wr_low_drives_data_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |-> mem_dq_oe);

    // R6
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_sel_n) && !$past(&mem_sel_n)) |-> $stable(mem_addr));

    // R9
    ack_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACKWAIT && !ack_s) |=> !mem_wr_n);

endmodule

// File: tb/amw_write_seq_test.sv
`timescale 1ns/1ps
module amw_write_seq_test;

    localparam int PH_SETUP  = 0;
    localparam int PH_STROBE = 1;
    localparam int PH_HOLD   = 2;
    localparam int PH_GAP    = 3;
    localparam int PH_IDLE   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cfg_wait = '0;
    logic [2:0]  cfg_hold = '0;
    logic        cfg_ack_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [1:0]  req_bank = '0;
    logic        mem_ack = 1'b1;
    logic [23:0] mem_addr;
    logic [3:0]  mem_sel_n;
    logic        mem_wr_n;
    logic        mem_rd_n;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    amw_write_seq uut (
        .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .cfg_ack_en(cfg_ack_en), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_bank(req_bank),
        .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_phase(input int ph, input logic [23:0] a, input logic [31:0] d,
                                input logic [1:0] b, input string req);
        bit act_b, oe_b, rdy_b, wr_b;
        logic [3:0] sel_e;
        act_b = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
        wr_b  = (ph == PH_STROBE);
        oe_b  = (ph == PH_STROBE) || (ph == PH_HOLD);
        rdy_b = (ph == PH_IDLE);
        sel_e = act_b ? ~(4'b0001 << b) : 4'hF;
        chk({mem_sel_n, mem_wr_n, mem_dq_oe, req_ready} == {sel_e, ~wr_b, oe_b, rdy_b},
            req, "sel/wr/oe/ready", longint'({mem_sel_n, mem_wr_n, mem_dq_oe, req_ready}),
            longint'({sel_e, ~wr_b, oe_b, rdy_b}));
        chk(mem_rd_n == 1'b1, "R12", "rd_n high", longint'(mem_rd_n), 1);
        if (act_b) chk(mem_addr == a, "R3", "address", longint'(mem_addr), longint'(a));
        if (oe_b) chk(mem_dq_o == d, "R5", "data", longint'(mem_dq_o), longint'(d));
    endtask

    function automatic string tag_of(input int ph);
        case (ph)
            PH_SETUP:  return "R3";
            PH_STROBE: return "R4";
            PH_HOLD:   return "R6";
            PH_GAP:    return "R6";
            default:   return "R2";
        endcase
    endfunction

    // Drives one request; returns at the sampling point of the SETUP clock,
    // with configuration and request fields scrambled (R11).
    task automatic issue(input logic [23:0] a, input logic [31:0] d, input logic [1:0] b,
                         input logic [4:0] w, input logic [2:0] h, input bit ae);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", longint'(req_ready), 1);
        req_addr = a; req_data = d; req_bank = b;
        cfg_wait = w; cfg_hold = h; cfg_ack_en = ae;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~a; req_data = ~d; req_bank = ~b;
        cfg_wait = ~w; cfg_hold = ~h; cfg_ack_en = ~ae;
    endtask

    task automatic t_plain(input logic [23:0] a, input logic [31:0] d, input logic [1:0] b,
                           input logic [4:0] w, input logic [2:0] h, input bit ae);
        int weff;
        int hh;
        weff = (w == 0) ? 1 : int'(w);
        hh = int'(h);
        issue(a, d, b, w, h, ae);
        for (int k = 0; k <= weff + hh + 2; k++) begin
            int ph;
            if (k > 0) @(negedge clk);
            if (k == 0) ph = PH_SETUP;
            else if (k <= weff) ph = PH_STROBE;
            else if (k <= weff + hh) ph = PH_HOLD;
            else if (k == weff + hh + 1) ph = PH_GAP;
            else ph = PH_IDLE;
            expect_phase(ph, a, d, b, tag_of(ph));
        end
    endtask

    // R9: acknowledge held low past the wait count, then raised
    task automatic t_ack(input logic [4:0] w, input logic [2:0] h, input int extra);
        int weff;
        int m;
        weff = (w == 0) ? 1 : int'(w);
        m = weff + extra;
        mem_ack = 1'b0;
        repeat (4) @(negedge clk);
        issue(24'h00A5A5, 32'hC0DE_0009, 2'd2, w, h, 1'b1);
        for (int k = 0; k <= m + 2 + int'(h) + 3; k++) begin
            int ph;
            if (k > 0) @(negedge clk);
            if (k == 0) ph = PH_SETUP;
            else if (k <= m + 2) ph = PH_STROBE;
            else if (k <= m + 2 + int'(h)) ph = PH_HOLD;
            else if (k == m + 3 + int'(h)) ph = PH_GAP;
            else ph = PH_IDLE;
            expect_phase(ph, 24'h00A5A5, 32'hC0DE_0009, 2'd2, "R9");
            if (k == m) mem_ack = 1'b1;
        end
    endtask

    // R10: acknowledge low but stretching disabled
    task automatic t_ack_off();
        mem_ack = 1'b0;
        repeat (4) @(negedge clk);
        t_plain(24'h0F0F0F, 32'h1234_0010, 2'd1, 5'd3, 3'd1, 1'b0);
        mem_ack = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // R7/R8: second request waiting while the first runs
    task automatic t_b2b(input logic [4:0] w, input logic [2:0] h);
        int weff;
        int rise1;
        int fall2;
        int oe_drop;
        bit prev_wr;
        bit prev_oe;
        bit saw_rdy;
        weff = (w == 0) ? 1 : int'(w);
        rise1 = -1; fall2 = -1; oe_drop = -1;
        @(negedge clk);
        req_addr = 24'h000111; req_data = 32'hAAAA_0001; req_bank = 2'd0;
        cfg_wait = w; cfg_hold = h; cfg_ack_en = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_addr = 24'h000222; req_data = 32'hBBBB_0002; req_bank = 2'd3;
        prev_wr = mem_wr_n; prev_oe = mem_dq_oe; saw_rdy = 1'b0;
        for (int k = 1; k < 2 * weff + 2 * int'(h) + 12; k++) begin
            @(negedge clk);
            if (saw_rdy) req_valid = 1'b0;
            if (req_ready && req_valid) saw_rdy = 1'b1;
            if (!prev_wr && mem_wr_n && rise1 < 0) rise1 = k;
            if (prev_oe && !mem_dq_oe && oe_drop < 0) oe_drop = k;
            if (prev_wr && !mem_wr_n && rise1 >= 0 && fall2 < 0) begin
                fall2 = k;
                chk(mem_dq_o == 32'hBBBB_0002, "R5", "second data", longint'(mem_dq_o), 32'hBBBB_0002);
                chk(mem_sel_n == 4'b0111, "R3", "second select", longint'(mem_sel_n), 4'b0111);
            end
            prev_wr = mem_wr_n; prev_oe = mem_dq_oe;
        end
        chk(fall2 - rise1 == int'(h) + 3, "R7", "strobe spacing", longint'(fall2 - rise1),
            longint'(int'(h) + 3));
        chk(fall2 - oe_drop >= 2 && oe_drop >= 0, "R8", "release lead",
            longint'(fall2 - oe_drop), 2);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // R1: reset in the middle of a strobe
    task automatic t_reset_mid();
        issue(24'h123456, 32'h5555_AAAA, 2'd1, 5'd10, 3'd2, 1'b0);
        repeat (3) @(negedge clk);
        chk(mem_wr_n == 1'b0, "R4", "strobe low before reset", longint'(mem_wr_n), 0);
        rst = 1'b1;
        @(negedge clk);
        expect_phase(PH_IDLE, '0, '0, '0, "R1");
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_phase(PH_IDLE, '0, '0, '0, "R1");
        repeat (3) @(negedge clk);
        t_plain(24'h000010, 32'hDEAD_BEEF, 2'd0, 5'd1, 3'd0, 1'b0);
        t_plain(24'h000020, 32'h0000_0001, 2'd1, 5'd0, 3'd3, 1'b0);
        t_plain(24'h7FFFFF, 32'hFFFF_0000, 2'd2, 5'd4, 3'd7, 1'b1);
        t_plain(24'hABCDEF, 32'h8000_0001, 2'd3, 5'd31, 3'd1, 1'b0);
        t_ack(5'd3, 3'd2, 5);
        t_ack(5'd0, 3'd0, 2);
        t_ack_off();
        t_b2b(5'd2, 3'd3);
        t_b2b(5'd1, 3'd0);
        t_reset_mid();
        t_plain(24'h00BEEF, 32'h0BAD_F00D, 2'd2, 5'd2, 3'd2, 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule